// File: doc/BRIEF.md
# Gated Falling-Edge Trigger Latch

This block holds one bit of state whose set and clear inputs are edge triggers with enable conditions, not level inputs. Each side has a group of active-low enable gates and one trigger line. A side acts only when its trigger makes a high-to-low transition while every gate on that side is already low. When it acts, it emits a pulse one clock wide that sets or clears the stored bit.

All inputs are sampled synchronously on a fast system clock. A trigger edge is found by comparing the previous trigger sample with the current one. The gate levels that decide the outcome are the ones sampled on the same clock edge as the first low trigger sample. A gate that becomes valid one sample later does not count. This matches a fault pattern where the trigger arrives before its qualifying condition and the latch then fails to change.

The block suits control latches in device controllers whose command decode and status gating settle at different steps of an execution cycle. The stored bit is driven out in both true and complement form.

Top module: `edge_gated_latch`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state is cleared: after that edge `q`=0, `q_n`=1, and `set_pulse` and `clr_pulse` are 0.
- R2: Let edge k be the first rising edge at which `set_trig` is sampled low, after it was sampled high at edge k-1. If every bit of `set_gate_n` is sampled low at edge k, `set_pulse` is 1 for the cycle after edge k, and `q` is 1 after edge k+1.
- R3: If any bit of the gate vector on a side is sampled high at edge k, that side produces no pulse and `q` keeps its value.
- R4: A gate that is high at edge k and goes low by edge k+1 does not cause the action. No pulse appears and `q` keeps its value.
- R5: A trigger that stays high, or stays low, produces no pulse and leaves `q` unchanged, whatever the gate levels.
- R6: A qualifying edge produces a pulse exactly one clock wide, even if the trigger then stays low.
- R7: The clear side is symmetric to the set side. A qualifying falling edge on `clr_trig` with all of `clr_gate_n` low raises `clr_pulse` for the cycle after edge k, and `q` is 0 after edge k+1.
- R8: If both sides qualify on the same edge, clear wins and `q` is 0 after edge k+1.
- R9: `q_n` is always the complement of `q`.
- R10: A trigger that is already low when `rst` is released is not treated as a falling edge.
- R11: A low-to-high trigger transition has no effect, even with all gates low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous power-on clear, active high |
| set_gate_n | input | SET_GATES | Active-low enable gates for the set side |
| set_trig | input | 1 | Set trigger, acts on its falling edge |
| clr_gate_n | input | CLR_GATES | Active-low enable gates for the clear side |
| clr_trig | input | 1 | Clear trigger, acts on its falling edge |
| q | output | 1 | Stored bit |
| q_n | output | 1 | Complement of the stored bit |
| set_pulse | output | 1 | One-cycle pulse when the set side qualifies |
| clr_pulse | output | 1 | One-cycle pulse when the clear side qualifies |

## Verification
A corrupted trigger history shows up at the ports one cycle after the sample that should or should not have fired. It appears as a missing or spurious pulse, and then as a wrong `q` one edge later. A wrong gate capture shows the same way: a late-arriving gate that wrongly fires is visible at the pulse output within one cycle. A stuck stored bit is visible immediately on `q` and `q_n`, and is checked after every set, clear and ignored stimulus.

// File: rtl/edge_gated_latch.sv
module edge_gated_latch #(
  parameter int SET_GATES = 3,
  parameter int CLR_GATES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [SET_GATES-1:0] set_gate_n,
  input  logic                 set_trig,
  input  logic [CLR_GATES-1:0] clr_gate_n,
  input  logic                 clr_trig,
  output logic                 q,
  output logic                 q_n,
  output logic                 set_pulse,
  output logic                 clr_pulse
);

  logic                 set_now, set_prev;
  logic                 clr_now, clr_prev;
  logic [SET_GATES-1:0] set_g;
  logic [CLR_GATES-1:0] clr_g;
  logic                 state;

  always_ff @(posedge clk) begin
    if (rst) begin
      set_now  <= 1'b0;
      set_prev <= 1'b0;
      clr_now  <= 1'b0;
      clr_prev <= 1'b0;
      set_g    <= '1;
      clr_g    <= '1;
    end else begin
      set_now  <= set_trig;
      set_prev <= set_now;
      clr_now  <= clr_trig;
      clr_prev <= clr_now;
      set_g    <= set_gate_n;
      clr_g    <= clr_gate_n;
    end
  end

  // fire only when the trigger fell and the gates captured with it are all low
  assign set_pulse = set_prev & ~set_now & ~(|set_g);
  assign clr_pulse = clr_prev & ~clr_now & ~(|clr_g);

  always_ff @(posedge clk) begin
    if (rst)            state <= 1'b0;
    else if (clr_pulse) state <= 1'b0;
    else if (set_pulse) state <= 1'b1;
  end

  assign q   = state;
  assign q_n = ~state;

  assert_set_cause_R2: assert property (@(posedge clk) disable iff (rst)
    set_pulse |-> (!$past(set_trig) && $past(set_trig, 2) && ($past(set_gate_n) == '0)));

  assert_clr_cause_R7: assert property (@(posedge clk) disable iff (rst)
    clr_pulse |-> (!$past(clr_trig) && $past(clr_trig, 2) && ($past(clr_gate_n) == '0)));

  assert_pulse_width_R6: assert property (@(posedge clk) disable iff (rst)
    (set_pulse |=> !set_pulse) and (clr_pulse |=> !clr_pulse));

  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (rst)
    clr_pulse |=> !q);

  assert_set_takes_R2: assert property (@(posedge clk) disable iff (rst)
    (set_pulse && !clr_pulse) |=> q);

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!set_pulse && !clr_pulse) |=> $stable(q));

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!q && !set_pulse && !clr_pulse));

  always_comb begin
    assert_complement_R9: assert (q_n == ~q);
  end

endmodule

// File: tb/edge_gated_latch_tb.sv
`timescale 1ns/1ps
module edge_gated_latch_tb_top;
  localparam int SG = 3;
  localparam int CG = 2;

  logic clk = 1'b0;
  logic rst;
  logic [SG-1:0] set_gate_n;
  logic set_trig;
  logic [CG-1:0] clr_gate_n;
  logic clr_trig;
  logic q, q_n, set_pulse, clr_pulse;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  edge_gated_latch #(.SET_GATES(SG), .CLR_GATES(CG)) dut_i (
    .clk(clk), .rst(rst), .set_gate_n(set_gate_n), .set_trig(set_trig),
    .clr_gate_n(clr_gate_n), .clr_trig(clr_trig),
    .q(q), .q_n(q_n), .set_pulse(set_pulse), .clr_pulse(clr_pulse));

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic idle();
    set_trig = 1'b1; clr_trig = 1'b1;
    set_gate_n = '1; clr_gate_n = '1;
    cyc(3);
  endtask

  task automatic fire_set(logic [SG-1:0] g);
    @(negedge clk);
    set_gate_n = g; set_trig = 1'b0;
    @(negedge clk);
  endtask

  task automatic fire_clr(logic [CG-1:0] g);
    @(negedge clk);
    clr_gate_n = g; clr_trig = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1; idle(); rst = 1'b0; cyc(1);
    check("R1 q", q, 1'b0);
    check("R1 q_n", q_n, 1'b1);
    check("R1 pulses", set_pulse | clr_pulse, 1'b0);
  endtask

  task automatic t_set();
    fire_set('0);
    check("R2 set_pulse", set_pulse, 1'b1);
    check("R2 clr_pulse quiet", clr_pulse, 1'b0);
    @(negedge clk);
    check("R2 q set", q, 1'b1);
    check("R9 q_n", q_n, 1'b0);
    check("R6 pulse ended", set_pulse, 1'b0);
    cyc(3);
    check("R6 trig held low", set_pulse, 1'b0);
    idle();
  endtask

  task automatic t_clr();
    fire_clr('0);
    check("R7 clr_pulse", clr_pulse, 1'b1);
    @(negedge clk);
    check("R7 q cleared", q, 1'b0);
    check("R9 q_n", q_n, 1'b1);
    check("R6 clr pulse ended", clr_pulse, 1'b0);
    idle();
  endtask

  task automatic t_gate_blocks();
    for (int b = 0; b < SG; b++) begin
      fire_set(SG'(1) << b);
      check("R3 set blocked pulse", set_pulse, 1'b0);
      @(negedge clk);
      check("R3 set blocked q", q, 1'b0);
      idle();
    end
    t_set();
    for (int b = 0; b < CG; b++) begin
      fire_clr(CG'(1) << b);
      check("R3 clr blocked pulse", clr_pulse, 1'b0);
      @(negedge clk);
      check("R3 clr blocked q", q, 1'b1);
      idle();
    end
    t_clr();
  endtask

  task automatic t_late_gate();
    fire_set('1);
    set_gate_n = '0;
    check("R4 late gate pulse", set_pulse, 1'b0);
    cyc(2);
    check("R4 late gate q", q, 1'b0);
    check("R4 late gate no pulse", set_pulse, 1'b0);
    idle();
  endtask

  task automatic t_steady();
    @(negedge clk);
    set_gate_n = '0; clr_gate_n = '0;
    set_trig = 1'b1; clr_trig = 1'b1;
    cyc(3);
    check("R5 steady high", q | set_pulse | clr_pulse, 1'b0);
    set_gate_n = '1;
    set_trig = 1'b0;
    cyc(1);
    set_gate_n = '0;
    cyc(3);
    check("R5 steady low", q | set_pulse, 1'b0);
    set_trig = 1'b1;
    cyc(1);
    check("R11 rising edge pulse", set_pulse, 1'b0);
    cyc(1);
    check("R11 rising edge q", q, 1'b0);
    idle();
  endtask

  task automatic t_both();
    t_set();
    @(negedge clk);
    set_gate_n = '0; clr_gate_n = '0;
    set_trig = 1'b0; clr_trig = 1'b0;
    @(negedge clk);
    check("R8 both pulses", set_pulse & clr_pulse, 1'b1);
    @(negedge clk);
    check("R8 clear wins", q, 1'b0);
    idle();
  endtask

  task automatic t_rst_low_trig();
    t_set();
    @(negedge clk);
    rst = 1'b1;
    set_gate_n = '0; set_trig = 1'b0;
    clr_gate_n = '0; clr_trig = 1'b0;
    cyc(2);
    check("R1 reset clears set bit", q, 1'b0);
    rst = 1'b0;
    cyc(4);
    check("R10 no pulse after release", set_pulse | clr_pulse, 1'b0);
    check("R10 q stays clear", q, 1'b0);
    idle();
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; set_trig = 1'b1; clr_trig = 1'b1;
    set_gate_n = '1; clr_gate_n = '1;
    t_reset();
    t_set();
    t_clr();
    t_gate_blocks();
    t_late_gate();
    t_steady();
    t_both();
    t_rst_low_trig();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule